// File: doc/BRIEF.md
# Dual-Clock Dual-Port 9-Bit RAM with Selectable Read Latency

This block is a true dual-port synchronous memory of 9-bit words. Each of its two ports runs on its own clock and has its own synchronous active-low reset, so either side can read or write any word at any time. Every port registers its address, its read/write control and its write data on the rising edge of its clock. It takes its access address from a small burst counter. The counter can be cleared, loaded from the address pins, advanced by one or held, so a caller can stream through consecutive words without presenting each address.

A static per-port mode pin sets the read latency. In flow-through mode, read data comes straight from the word addressed on the last edge. In pipelined mode, that word passes through one more output register and appears one cycle later. Two chip-select pins gate each port, one active low and one active high. An output-enable pin, active low and not clocked, blanks the read bus at any moment. The read side is presented as a data bus plus a drive flag rather than as a three-state pad. When the flag is low, the bus reads zero.

Depth is 2**ADDR_W words: 13 gives 8K and 14 gives 16K. The default is kept small so that a plain elaboration stays light.

Top module: `dual_port_ram9`

## Requirements
- R1: While a port's reset is low, its drive flag is 0 and its read bus is 0, and its burst counter returns to address 0. A write on the first edge after reset with load, clear and advance all inactive lands at address 0.
- R2: A word written through either port is returned by a read through the other port that is registered on a later edge of that other port's clock.
- R3: In flow-through mode (mode pin 0), a read registered on an edge presents the addressed word, with the drive flag 1, in the cycle that follows that same edge.
- R4: In pipelined mode (mode pin 1), the drive flag and read data during a cycle reflect the access registered two edges earlier, one cycle later than in flow-through mode.
- R5: A port is selected only when select-0 is 0 and select-1 is 1. After an unselected edge, the drive flag falls in the next cycle in flow-through mode and one cycle later in pipelined mode. In pipelined mode, one selected read cycle must pass before the drive flag rises again.
- R6: While output-enable is 1, the drive flag is 0 and the read bus is 0. The gating follows the pin at once, with no clock edge needed.
- R7: Read/write is sampled on the rising edge: 1 reads and 0 writes. A selected write stores the word on the edge that registers it, and the port does not drive its bus for that access.
- R8: Counter clear (active low) forces the access address of that edge to 0 and takes priority over load and advance.
- R9: Load (active low), when clear is inactive, makes the address pins the access address of that edge. It takes priority over advance. The counter acts whatever the chip selects are.
- R10: Advance (active low), when clear and load are inactive, makes the access address the previous one plus 1, wrapping from the last word to 0. With all three inactive, the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A synchronous reset, active low |
| a_addr | input | ADDR_W | Port A external address |
| a_ld_n | input | 1 | Port A counter load, active low |
| a_adv_n | input | 1 | Port A counter advance, active low |
| a_clr_n | input | 1 | Port A counter clear, active low |
| a_we_n | input | 1 | Port A read (1) / write (0) |
| a_sel0_n | input | 1 | Port A select, active low |
| a_sel1 | input | 1 | Port A select, active high |
| a_pipe | input | 1 | Port A latency mode: 0 flow-through, 1 pipelined |
| a_oe_n | input | 1 | Port A output enable, active low, not clocked |
| a_wdata | input | 9 | Port A write data |
| a_rdata | output | 9 | Port A read data, zero when not driven |
| a_rdrive | output | 1 | Port A read bus driven |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B synchronous reset, active low |
| b_addr | input | ADDR_W | Port B external address |
| b_ld_n | input | 1 | Port B counter load, active low |
| b_adv_n | input | 1 | Port B counter advance, active low |
| b_clr_n | input | 1 | Port B counter clear, active low |
| b_we_n | input | 1 | Port B read (1) / write (0) |
| b_sel0_n | input | 1 | Port B select, active low |
| b_sel1 | input | 1 | Port B select, active high |
| b_pipe | input | 1 | Port B latency mode: 0 flow-through, 1 pipelined |
| b_oe_n | input | 1 | Port B output enable, active low, not clocked |
| b_wdata | input | 9 | Port B write data |
| b_rdata | output | 9 | Port B read data, zero when not driven |
| b_rdrive | output | 1 | Port B read bus driven |

## Verification
The hardest situation to reach from the ports is the hand-over between the two clock domains. One port must commit a word, and the other port must pick it up on its own unrelated clock, sometimes through the extra pipelined register. The bench runs the two clocks at incommensurate periods, so their edges never coincide. It writes on one port, then reads the same word on the other after that port's next edge, in both latency modes. The cycle-late release and re-arm of the pipelined output is reached by deselecting a port and dropping a write into a stream of pipelined reads. Output-enable is also toggled between clock edges.

// File: rtl/dpr_pkg.sv
`timescale 1ns/100ps
// Shared types for the dual-clock 9-bit RAM.
// Assumes: word width is fixed at 9 bits; two ports, three lookups per bank.
package dpr_pkg;
    localparam int WORD_W  = 9;
    localparam int N_LOOK  = 3;
    typedef logic [WORD_W-1:0] word_t;

    // Choose the bank holding the newest copy: bank A owns a word when the tags differ.
    function automatic word_t pick_latest(input logic tag_a, input logic tag_b,
                                          input word_t word_a, input word_t word_b);
        return (tag_a ^ tag_b) ? word_a : word_b;
    endfunction
endpackage

// File: rtl/dpr_burst_ctr.sv
`timescale 1ns/100ps
// Burst address counter for one port.
// Produces the access address of the coming edge (nxt_addr) and holds it
// afterwards as the registered address (cur_addr).
// Priority: clear, then load, then advance, otherwise hold. Independent of selects.
// Assumes: all controls synchronous to clk, active low.
module dpr_burst_ctr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ext_addr,
    input  logic          ld_n,
    input  logic          adv_n,
    input  logic          clr_n,
    output logic [AW-1:0] nxt_addr,
    output logic [AW-1:0] cur_addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // Select the access address for the coming edge by control priority.
    always_comb begin
        if (!clr_n)      nxt_addr = '0;
        else if (!ld_n)  nxt_addr = ext_addr;
        else if (!adv_n) nxt_addr = cur_addr + ONE;
        else             nxt_addr = cur_addr;
    end

    // Register the access address; it doubles as the counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_addr <= '0;
        else        cur_addr <= nxt_addr;
    end

    a_r8_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (cur_addr == '0));
    a_r9_load_takes_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !ld_n) |=> (cur_addr == $past(ext_addr)));
    a_r10_advance_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && !adv_n) |=> (cur_addr == $past(cur_addr) + ONE));
    a_r10_hold_address: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && adv_n) |=> $stable(cur_addr));
endmodule

// File: rtl/dpr_bank.sv
`timescale 1ns/100ps
// One storage bank written by a single port's clock, plus a one-bit tag per word.
// Two banks with complementary tag rules form a dual-clock RAM without a
// shared write path: the tag pair tells which bank wrote a word last.
// Assumes: no reset on storage; simultaneous same-word writes leave the word undefined.
module dpr_bank
    import dpr_pkg::*;
#(
    parameter int AW     = 10,
    parameter bit INVERT = 1'b0
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  word_t                       wr_data,
    input  logic                        peer_tag,
    input  logic [N_LOOK-1:0][AW-1:0]   look_addr,
    output logic [N_LOOK-1:0]           look_tag,
    output logic [N_LOOK-1:0][WORD_W-1:0] look_word
);
    localparam int DEPTH = 1 << AW;

    word_t store    [DEPTH];
    logic  tag_bits [DEPTH];

    // Commit a write and mark this bank as the newest owner of the word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr]    <= wr_data;
            tag_bits[wr_addr] <= INVERT ? ~peer_tag : peer_tag;
        end
    end

    // Asynchronous lookups for both ports' reads and the peer's tag update.
    for (genvar i = 0; i < N_LOOK; i++) begin : g_look
        assign look_tag[i]  = tag_bits[look_addr[i]];
        assign look_word[i] = store[look_addr[i]];
    end
endmodule

// File: rtl/dpr_read_stage.sv
`timescale 1ns/100ps
// Read output stage of one port: registers select and read/write, keeps an
// optional output register, and applies the unclocked output enable.
// Flow-through uses the array word of the registered address; pipelined uses
// the output register, so every state change shows up one cycle later.
// Assumes: pipe_mode is static in normal use.
module dpr_read_stage
    import dpr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  acc_en,
    input  logic  rd_req,
    input  logic  pipe_mode,
    input  logic  oe_n,
    input  word_t arr_word,
    output word_t rdata,
    output logic  drive
);
    logic  sel_q, rd_q, pipe_drv;
    word_t pipe_word;
    logic  raw_drv;

    // Register access controls, then the pipelined copy of the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= 1'b0;
            rd_q      <= 1'b0;
            pipe_drv  <= 1'b0;
            pipe_word <= '0;
        end else begin
            sel_q     <= acc_en;
            rd_q      <= rd_req;
            pipe_drv  <= sel_q & rd_q;
            pipe_word <= arr_word;
        end
    end

    // Pick the latency path and gate it with the output enable.
    always_comb begin
        raw_drv = pipe_mode ? pipe_drv : (sel_q & rd_q);
        drive   = raw_drv & ~oe_n;
        rdata   = drive ? (pipe_mode ? pipe_word : arr_word) : '0;
    end

    a_r5_flow_deselect_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && !acc_en) |=> (pipe_mode || !drive));
    a_r4_pipe_deselect_late: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !acc_en ##1 pipe_mode) |=> !drive);
    a_r7_write_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && acc_en && !rd_req) |=> (pipe_mode || !drive));
    a_r6_oe_blanks_bus: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!drive && rdata == '0));
endmodule

// File: rtl/dual_port_ram9.sv
`timescale 1ns/100ps
// Dual-clock, dual-port RAM of 9-bit words with per-port burst counters and a
// per-port choice of flow-through or pipelined read latency.
// Storage is split into two banks, each written by one port; tag bits select
// the newest copy on reads.
// Assumes: clocks unrelated; simultaneous writes to one word give an undefined word.
module dual_port_ram9
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              a_clk,
    input  logic              a_rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_ld_n,
    input  logic              a_adv_n,
    input  logic              a_clr_n,
    input  logic              a_we_n,
    input  logic              a_sel0_n,
    input  logic              a_sel1,
    input  logic              a_pipe,
    input  logic              a_oe_n,
    input  logic [WORD_W-1:0] a_wdata,
    output logic [WORD_W-1:0] a_rdata,
    output logic              a_rdrive,
    input  logic              b_clk,
    input  logic              b_rst_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_ld_n,
    input  logic              b_adv_n,
    input  logic              b_clr_n,
    input  logic              b_we_n,
    input  logic              b_sel0_n,
    input  logic              b_sel1,
    input  logic              b_pipe,
    input  logic              b_oe_n,
    input  logic [WORD_W-1:0] b_wdata,
    output logic [WORD_W-1:0] b_rdata,
    output logic              b_rdrive
);
    localparam int NP = 2;

    logic [NP-1:0]              clk_v, rst_v, ld_v, adv_v, clr_v, we_v, s0_v, s1_v, pipe_v, oe_v;
    logic [NP-1:0]              sel_now, wr_en, drv_v;
    logic [NP-1:0][ADDR_W-1:0]  ext_v, nxt_v, cur_v;
    logic [NP-1:0][WORD_W-1:0]  wd_v, rd_v, arr_v;

    logic [N_LOOK-1:0][ADDR_W-1:0] look_a_addr, look_b_addr;
    logic [N_LOOK-1:0]             look_a_tag, look_b_tag;
    logic [N_LOOK-1:0][WORD_W-1:0] look_a_word, look_b_word;

    // Gather the two ports' pins into indexed vectors.
    assign clk_v  = {b_clk,    a_clk};
    assign rst_v  = {b_rst_n,  a_rst_n};
    assign ld_v   = {b_ld_n,   a_ld_n};
    assign adv_v  = {b_adv_n,  a_adv_n};
    assign clr_v  = {b_clr_n,  a_clr_n};
    assign we_v   = {b_we_n,   a_we_n};
    assign s0_v   = {b_sel0_n, a_sel0_n};
    assign s1_v   = {b_sel1,   a_sel1};
    assign pipe_v = {b_pipe,   a_pipe};
    assign oe_v   = {b_oe_n,   a_oe_n};
    assign ext_v  = {b_addr,   a_addr};
    assign wd_v   = {b_wdata,  a_wdata};

    assign a_rdata  = rd_v[0];
    assign a_rdrive = drv_v[0];
    assign b_rdata  = rd_v[1];
    assign b_rdrive = drv_v[1];

    // Lookup slots: 0 = port A read, 1 = port B read, 2 = peer port's write address.
    assign look_a_addr = {nxt_v[1], cur_v[1], cur_v[0]};
    assign look_b_addr = {nxt_v[0], cur_v[1], cur_v[0]};

    dpr_bank #(.AW(ADDR_W), .INVERT(1'b1)) bank_a_i (
        .clk       (a_clk),
        .wr_en     (wr_en[0]),
        .wr_addr   (nxt_v[0]),
        .wr_data   (wd_v[0]),
        .peer_tag  (look_b_tag[2]),
        .look_addr (look_a_addr),
        .look_tag  (look_a_tag),
        .look_word (look_a_word)
    );

    dpr_bank #(.AW(ADDR_W), .INVERT(1'b0)) bank_b_i (
        .clk       (b_clk),
        .wr_en     (wr_en[1]),
        .wr_addr   (nxt_v[1]),
        .wr_data   (wd_v[1]),
        .peer_tag  (look_a_tag[2]),
        .look_addr (look_b_addr),
        .look_tag  (look_b_tag),
        .look_word (look_b_word)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        // Decode selection and the write strobe of this port.
        assign sel_now[p] = ~s0_v[p] & s1_v[p];
        assign wr_en[p]   = rst_v[p] & sel_now[p] & ~we_v[p];
        // Resolve the newest copy of the word this port addresses.
        assign arr_v[p]   = pick_latest(look_a_tag[p], look_b_tag[p],
                                        look_a_word[p], look_b_word[p]);

        dpr_burst_ctr #(.AW(ADDR_W)) ctr_i (
            .clk      (clk_v[p]),
            .rst_n    (rst_v[p]),
            .ext_addr (ext_v[p]),
            .ld_n     (ld_v[p]),
            .adv_n    (adv_v[p]),
            .clr_n    (clr_v[p]),
            .nxt_addr (nxt_v[p]),
            .cur_addr (cur_v[p])
        );

        dpr_read_stage rd_i (
            .clk       (clk_v[p]),
            .rst_n     (rst_v[p]),
            .acc_en    (sel_now[p]),
            .rd_req    (we_v[p]),
            .pipe_mode (pipe_v[p]),
            .oe_n      (oe_v[p]),
            .arr_word  (arr_v[p]),
            .rdata     (rd_v[p]),
            .drive     (drv_v[p])
        );
    end
endmodule

// File: tb/dual_port_ram9_tb_top.sv
`timescale 1ns/100ps
module dual_port_ram9_tb_top;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic [1:0] rst_n, we_n, ld_n, adv_n, clr_n, s0_n, s1, pipe, oe_n;
    logic [AW-1:0] addr [2];
    logic [8:0]    wdata [2];
    logic [8:0]    a_rdata, b_rdata;
    logic          a_rdrive, b_rdrive;

    int n_chk = 0, n_fail = 0;
    string req_tag [2];

    // Reference model state
    int mem [int];
    int m_cnt [2];
    bit m_sel [2], m_rd [2], m_pdrv [2], seen [2];
    int m_pval [2];

    always #2 clk_a = ~clk_a;
    initial begin
        #1;
        forever #3.5 clk_b = ~clk_b;
    end

    dual_port_ram9 #(.ADDR_W(AW)) dut_i (
        .a_clk(clk_a), .a_rst_n(rst_n[0]), .a_addr(addr[0]), .a_ld_n(ld_n[0]),
        .a_adv_n(adv_n[0]), .a_clr_n(clr_n[0]), .a_we_n(we_n[0]), .a_sel0_n(s0_n[0]),
        .a_sel1(s1[0]), .a_pipe(pipe[0]), .a_oe_n(oe_n[0]), .a_wdata(wdata[0]),
        .a_rdata(a_rdata), .a_rdrive(a_rdrive),
        .b_clk(clk_b), .b_rst_n(rst_n[1]), .b_addr(addr[1]), .b_ld_n(ld_n[1]),
        .b_adv_n(adv_n[1]), .b_clr_n(clr_n[1]), .b_we_n(we_n[1]), .b_sel0_n(s0_n[1]),
        .b_sel1(s1[1]), .b_pipe(pipe[1]), .b_oe_n(oe_n[1]), .b_wdata(wdata[1]),
        .b_rdata(b_rdata), .b_rdrive(b_rdrive)
    );

    function automatic int rd_of(int p);
        return (p == 0) ? int'(a_rdata) : int'(b_rdata);
    endfunction
    function automatic int drv_of(int p);
        return (p == 0) ? int'(a_rdrive) : int'(b_rdrive);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Model one rising edge of port p from the inputs it sees.
    task automatic model_edge(int p);
        int nx;
        seen[p] = 1'b1;
        if (!rst_n[p]) begin
            m_cnt[p] = 0; m_sel[p] = 0; m_rd[p] = 0; m_pdrv[p] = 0; m_pval[p] = 0;
            return;
        end
        m_pval[p] = mem.exists(m_cnt[p]) ? mem[m_cnt[p]] : -1;
        m_pdrv[p] = m_sel[p] && m_rd[p];
        if (!clr_n[p])      nx = 0;
        else if (!ld_n[p])  nx = int'(addr[p]);
        else if (!adv_n[p]) nx = (m_cnt[p] + 1) % DEPTH;
        else                nx = m_cnt[p];
        m_sel[p] = !s0_n[p] && s1[p];
        m_rd[p]  = we_n[p];
        if (m_sel[p] && !we_n[p]) mem[nx] = int'(wdata[p]);
        m_cnt[p] = nx;
    endtask

    // Compare port p against the model away from the active edge.
    task automatic compare(int p);
        bit ed;
        int ev;
        if (!seen[p]) return;
        ed = (pipe[p] ? m_pdrv[p] : (m_sel[p] && m_rd[p])) && !oe_n[p];
        if (!ed)          ev = 0;
        else if (pipe[p]) ev = m_pval[p];
        else              ev = mem.exists(m_cnt[p]) ? mem[m_cnt[p]] : -1;
        chk({req_tag[p], " per-cycle drive"}, drv_of(p), int'(ed));
        if (ev >= 0) chk({req_tag[p], " per-cycle data"}, rd_of(p), ev);
    endtask

    always @(posedge clk_a) model_edge(0);
    always @(posedge clk_b) model_edge(1);
    always @(negedge clk_a) compare(0);
    always @(negedge clk_b) compare(1);

    // Apply one access on port p and return just after the following falling edge.
    task automatic op(int p, bit w_n, bit l_n, bit a_n, bit c_n, bit z0_n, bit z1,
                      bit o_n, int ad, int d);
        we_n[p] = w_n; ld_n[p] = l_n; adv_n[p] = a_n; clr_n[p] = c_n;
        s0_n[p] = z0_n; s1[p] = z1; oe_n[p] = o_n;
        addr[p] = AW'(ad); wdata[p] = 9'(d);
        if (p == 0) begin @(posedge clk_a); @(negedge clk_a); end
        else        begin @(posedge clk_b); @(negedge clk_b); end
        #0.1;
    endtask

    task automatic rd_ld(int p, int a);          op(p, 1, 0, 1, 1, 0, 1, 0, a, 0); endtask
    task automatic wr_ld(int p, int a, int d);   op(p, 0, 0, 1, 1, 0, 1, 0, a, d); endtask
    task automatic wr_adv(int p, int d);         op(p, 0, 1, 0, 1, 0, 1, 0, 0, d); endtask
    task automatic wr_hold(int p, int d);        op(p, 0, 1, 1, 1, 0, 1, 0, 0, d); endtask
    task automatic rd_adv(int p);                op(p, 1, 1, 0, 1, 0, 1, 0, 0, 0); endtask
    task automatic rd_hold(int p);               op(p, 1, 1, 1, 1, 0, 1, 0, 0, 0); endtask
    task automatic desel0(int p);                op(p, 1, 1, 1, 1, 1, 1, 0, 0, 0); endtask
    task automatic desel1(int p);                op(p, 1, 1, 1, 1, 0, 0, 0, 0, 0); endtask
    task automatic clr_ld(int p, int a);         op(p, 1, 0, 1, 0, 0, 1, 0, a, 0); endtask
    task automatic rd_oe_off(int p);             op(p, 1, 1, 1, 1, 0, 1, 1, 0, 0); endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 2'b00; we_n = 2'b11; ld_n = 2'b11; adv_n = 2'b11; clr_n = 2'b11;
        s0_n = 2'b11; s1 = 2'b00; pipe = 2'b00; oe_n = 2'b00;
        addr[0] = '0; addr[1] = '0; wdata[0] = '0; wdata[1] = '0;
        req_tag[0] = "R1"; req_tag[1] = "R1";

        repeat (4) @(negedge clk_b);
        #0.1;
        chk("R1 port A drive in reset", int'(a_rdrive), 0);
        chk("R1 port B drive in reset", int'(b_rdrive), 0);
        chk("R1 port A data in reset", int'(a_rdata), 0);
        rst_n = 2'b11;

        // R1: counter starts at 0 after reset
        wr_hold(0, 'h0AB);
        rd_ld(0, 0);
        chk("R1 counter zero after reset", int'(a_rdata), 'h0AB);

        // R7 then R3 and R10 in flow-through mode
        req_tag[0] = "R7";
        wr_ld(0, 5, 'h123);
        chk("R7 write cycle undriven", int'(a_rdrive), 0);
        wr_adv(0, 'h0F0);
        wr_adv(0, 'h00F);
        req_tag[0] = "R3";
        rd_ld(0, 5);
        chk("R3 flow read drive", int'(a_rdrive), 1);
        chk("R3 flow read data", int'(a_rdata), 'h123);
        req_tag[0] = "R10";
        rd_adv(0);
        chk("R10 advance", int'(a_rdata), 'h0F0);
        rd_hold(0);
        chk("R10 hold", int'(a_rdata), 'h0F0);
        rd_adv(0);
        chk("R10 advance again", int'(a_rdata), 'h00F);
        wr_ld(0, DEPTH - 1, 'h0AA);
        wr_adv(0, 'h155);
        rd_ld(0, 0);
        chk("R10 wrap to 0", int'(a_rdata), 'h155);
        rd_ld(0, DEPTH - 1);
        chk("R10 last word", int'(a_rdata), 'h0AA);

        // R8 clear beats load; R9 load
        req_tag[0] = "R8";
        rd_ld(0, 6);
        clr_ld(0, 7);
        chk("R8 clear over load", int'(a_rdata), 'h155);
        req_tag[0] = "R9";
        rd_ld(0, 7);
        chk("R9 load pins", int'(a_rdata), 'h00F);

        // R5 flow-through deselect through each select pin
        req_tag[0] = "R5";
        desel0(0);
        chk("R5 flow select-0 off", int'(a_rdrive), 0);
        rd_hold(0);
        chk("R5 flow reselect", int'(a_rdata), 'h00F);
        desel1(0);
        chk("R5 flow select-1 off", int'(a_rdrive), 0);
        rd_hold(0);

        // R6 output enable, clocked and between edges
        req_tag[0] = "R6";
        rd_oe_off(0);
        chk("R6 oe high drive", int'(a_rdrive), 0);
        chk("R6 oe high data", int'(a_rdata), 0);
        rd_hold(0);
        oe_n[0] = 1'b1;
        #0.2;
        chk("R6 async oe off", int'(a_rdrive), 0);
        oe_n[0] = 1'b0;
        #0.2;
        chk("R6 async oe on", int'(a_rdata), 'h00F);

        // R2 cross-port in both directions
        req_tag[0] = "R2"; req_tag[1] = "R2";
        wr_ld(0, 20, 'h1A5);
        rd_ld(1, 20);
        chk("R2 A write seen by B", int'(b_rdata), 'h1A5);
        wr_ld(1, 21, 'h05A);
        desel0(1);
        rd_ld(0, 21);
        chk("R2 B write seen by A", int'(a_rdata), 'h05A);

        // R4 pipelined latency on port A
        req_tag[0] = "R4";
        pipe[0] = 1'b1;
        rd_ld(0, 5);
        chk("R4 pipe shows older word", int'(a_rdata), 'h05A);
        rd_hold(0);
        chk("R4 pipe word one cycle late", int'(a_rdata), 'h123);

        // R5 pipelined deselect late, re-arm after one selected cycle
        req_tag[0] = "R5";
        desel0(0);
        chk("R5 pipe still driving", int'(a_rdrive), 1);
        rd_hold(0);
        chk("R5 pipe released late", int'(a_rdrive), 0);
        rd_hold(0);
        chk("R5 pipe re-armed", int'(a_rdata), 'h123);

        // R7 pipelined write hole
        req_tag[0] = "R7";
        wr_ld(0, 30, 'h0C3);
        rd_hold(0);
        chk("R7 pipe write undriven", int'(a_rdrive), 0);
        rd_hold(0);
        chk("R7 pipe read after write", int'(a_rdata), 'h0C3);

        // R4 and R2 on port B pipelined
        req_tag[1] = "R4";
        pipe[1] = 1'b1;
        rd_ld(1, 30);
        rd_hold(1);
        chk("R4 B pipe reads A word", int'(b_rdata), 'h0C3);
        req_tag[1] = "R2";
        wr_ld(1, 5, 'h1FF);
        desel0(1);
        req_tag[0] = "R2";
        rd_ld(0, 5);
        rd_hold(0);
        chk("R2 B overwrite seen by A pipe", int'(a_rdata), 'h1FF);

        repeat (3) @(negedge clk_b);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule